// File: doc/BRIEF.md
# Speculative Commit Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Each instruction is given an entry when it issues, and the index of that entry is returned as the tag that later names its result. Entries are handed out in program order at the tail of a circular 16-slot ring. Up to two can be handed out per cycle. The instruction issues only if the requester already holds a free reservation station and the buffer grants the slot.

Results come back in any order on two result buses. A result is written into the entry named by its tag. Architectural state is not touched at that point. The head entry retires once its result is present: a register operation asks for a register write, a store asks for a memory write, and a correctly predicted branch just frees its slot. A second entry can retire in the same cycle behind the head. When a branch flagged as mispredicted reaches the head, the buffer raises flush and drops every entry, which cancels all younger speculative work.

Top module: `commit_buffer`

## Requirements
- R1: The buffer holds DEPTH (16) entries as a ring. Slot 0 of the allocate port gets the tag equal to the tail index, and slot 1 gets the next index. Tags advance by the number granted and wrap modulo 16.
- R2: Slot 0 is granted when it is requested and at least one entry is free. Slot 1 is granted only when both slots are requested and at least two entries are free. A full buffer grants nothing. Entries freed by commits in the same cycle are not counted as free.
- R3: A result-bus write to an allocated entry that is still waiting marks it ready, and the entry can commit from the next cycle on. The mispredict bit is kept only for branch entries. Bus writes to an entry that is not allocated at that time are ignored. If both buses name the same tag, bus 1 wins.
- R4: Only the head entry can commit, and only once it is ready. Commit outputs follow the entry's kind code: 0 (register op) raises the register write, 1 (store) raises the memory write, and 2 (branch) raises neither. Destination and data come from the entry.
- R5: Slot 1 commits the entry after the head only when three things hold in that cycle: the head commits, that entry is ready, and that entry is not a mispredicted branch.
- R6: A ready branch at the head with its mispredict bit set raises flush for that cycle. Neither slot then writes. On the next cycle the buffer is empty, and the next tag is the index just after the branch.
- R7: No allocation is granted in a cycle in which flush is high.
- R8: After reset the buffer is empty with both pointers at 0, so the first tag is 0. No commit or flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc0_req | input | 1 | Request an entry for the older instruction |
| alloc0_kind | input | 2 | Kind code: 0 register op, 1 store, 2 branch |
| alloc0_dst | input | REG_W | Destination register, or store-buffer index for a store |
| alloc1_req | input | 1 | Request an entry for the younger instruction |
| alloc1_kind | input | 2 | Kind code of the younger instruction |
| alloc1_dst | input | REG_W | Destination of the younger instruction |
| alloc0_gnt | output | 1 | Older instruction was given an entry |
| alloc1_gnt | output | 1 | Younger instruction was given an entry |
| alloc0_tag | output | log2(DEPTH) | Tag for the older instruction |
| alloc1_tag | output | log2(DEPTH) | Tag for the younger instruction |
| res0_valid | input | 1 | Result bus 0 carries a result |
| res0_tag | input | log2(DEPTH) | Entry named by bus 0 |
| res0_data | input | DATA_W | Result value on bus 0 |
| res0_mispred | input | 1 | Bus 0 reports a mispredicted branch |
| res1_valid | input | 1 | Result bus 1 carries a result |
| res1_tag | input | log2(DEPTH) | Entry named by bus 1 |
| res1_data | input | DATA_W | Result value on bus 1 |
| res1_mispred | input | 1 | Bus 1 reports a mispredicted branch |
| cmt0_reg_we | output | 1 | Oldest commit writes a register |
| cmt0_mem_we | output | 1 | Oldest commit writes memory |
| cmt0_dst | output | REG_W | Destination of the oldest commit |
| cmt0_data | output | DATA_W | Value of the oldest commit |
| cmt1_reg_we | output | 1 | Second commit writes a register |
| cmt1_mem_we | output | 1 | Second commit writes memory |
| cmt1_dst | output | REG_W | Destination of the second commit |
| cmt1_data | output | DATA_W | Value of the second commit |
| flush | output | 1 | Mispredicted branch at head, all entries cancelled |

## Verification
Allocation and commit can happen in the same cycle. So can result capture and commit, and each of these can coincide with a flush. The vector table makes pairs complete either together or youngest-first. It then checks that nothing retires until the head is ready and that both entries retire in one cycle, while tags keep wrapping around the ring. Directed cases put a mispredicted branch right behind a ready register op, so that slot 1 must hold back while slot 0 commits. They also request an allocation during a flush cycle and expect it to be refused, and send a stale bus write to a freed slot just before that slot is reused. The new occupant must then stay pending until its own result arrives.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = IW + 1
) (
  input  logic [PW-1:0] head_ptr,
  input  logic [PW-1:0] tail_ptr,
  input  logic          req0,
  input  logic          req1,
  input  logic          hold,
  output logic          gnt0,
  output logic          gnt1,
  output logic [IW-1:0] tag0,
  output logic [IW-1:0] tag1,
  output logic [PW-1:0] occ
);
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONE = (PW+1)'(1);
  localparam logic [PW:0] TWO = (PW+1)'(2);

  // occupancy from wrap-extended pointers
  function automatic logic [PW-1:0] ptr_dist(input logic [PW-1:0] h, input logic [PW-1:0] t);
    return t - h;
  endfunction

  logic [PW:0] free_cnt;

  assign occ      = ptr_dist(head_ptr, tail_ptr);
  assign free_cnt = CAP - {1'b0, occ};
  assign gnt0     = req0 && !hold && (free_cnt >= ONE);
  assign gnt1     = req0 && req1 && !hold && (free_cnt >= TWO);
  assign tag0     = tail_ptr[IW-1:0];
  assign tag1     = tail_ptr[IW-1:0] + IW'(1);
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
(
  input  logic     h0_valid,
  input  logic     h0_ready,
  input  op_kind_e h0_kind,
  input  logic     h0_mis,
  input  logic     h1_valid,
  input  logic     h1_ready,
  input  op_kind_e h1_kind,
  input  logic     h1_mis,
  output logic     fire0,
  output logic     fire1,
  output logic     flush
);
  logic h0_done, h1_bad;

  assign h0_done = h0_valid && h0_ready;
  assign flush   = h0_done && (h0_kind == K_BRANCH) && h0_mis;
  assign fire0   = h0_done && !flush;
  assign h1_bad  = (h1_kind == K_BRANCH) && h1_mis;
  assign fire1   = fire0 && h1_valid && h1_ready && !h1_bad;
endmodule

// File: rtl/commit_buffer.sv
module commit_buffer
  import rob_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int REG_W  = 5,
  parameter  int DATA_W = 32,
  localparam int IW     = $clog2(DEPTH),
  localparam int PW     = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc0_req,
  input  logic [1:0]        alloc0_kind,
  input  logic [REG_W-1:0]  alloc0_dst,
  input  logic              alloc1_req,
  input  logic [1:0]        alloc1_kind,
  input  logic [REG_W-1:0]  alloc1_dst,
  output logic              alloc0_gnt,
  output logic              alloc1_gnt,
  output logic [IW-1:0]     alloc0_tag,
  output logic [IW-1:0]     alloc1_tag,
  input  logic              res0_valid,
  input  logic [IW-1:0]     res0_tag,
  input  logic [DATA_W-1:0] res0_data,
  input  logic              res0_mispred,
  input  logic              res1_valid,
  input  logic [IW-1:0]     res1_tag,
  input  logic [DATA_W-1:0] res1_data,
  input  logic              res1_mispred,
  output logic              cmt0_reg_we,
  output logic              cmt0_mem_we,
  output logic [REG_W-1:0]  cmt0_dst,
  output logic [DATA_W-1:0] cmt0_data,
  output logic              cmt1_reg_we,
  output logic              cmt1_mem_we,
  output logic [REG_W-1:0]  cmt1_dst,
  output logic [DATA_W-1:0] cmt1_data,
  output logic              flush
);
  typedef struct packed {
    logic              valid;
    logic              ready;
    op_kind_e          kind;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] data;
    logic              mis;
  } slot_t;

  slot_t          slots_q [DEPTH];
  slot_t          slots_d [DEPTH];
  logic [PW-1:0]  head_q, tail_q, head_d, tail_d, occ;
  logic [IW-1:0]  head_idx, next_idx;
  slot_t          h0, h1;
  logic           fire0, fire1;

  assign head_idx = head_q[IW-1:0];
  assign next_idx = head_idx + IW'(1);
  assign h0       = slots_q[head_idx];
  assign h1       = slots_q[next_idx];

  rob_alloc_ctrl #(.DEPTH(DEPTH)) u_alloc (
    .head_ptr (head_q),
    .tail_ptr (tail_q),
    .req0     (alloc0_req),
    .req1     (alloc1_req),
    .hold     (flush),
    .gnt0     (alloc0_gnt),
    .gnt1     (alloc1_gnt),
    .tag0     (alloc0_tag),
    .tag1     (alloc1_tag),
    .occ      (occ)
  );

  rob_retire_sel u_retire (
    .h0_valid (h0.valid),
    .h0_ready (h0.ready),
    .h0_kind  (h0.kind),
    .h0_mis   (h0.mis),
    .h1_valid (h1.valid),
    .h1_ready (h1.ready),
    .h1_kind  (h1.kind),
    .h1_mis   (h1.mis),
    .fire0    (fire0),
    .fire1    (fire1),
    .flush    (flush)
  );

  // commit requests are decoded from the head entries
  assign cmt0_reg_we = fire0 && (h0.kind == K_REG);
  assign cmt0_mem_we = fire0 && (h0.kind == K_STORE);
  assign cmt0_dst    = h0.dst;
  assign cmt0_data   = h0.data;
  assign cmt1_reg_we = fire1 && (h1.kind == K_REG);
  assign cmt1_mem_we = fire1 && (h1.kind == K_STORE);
  assign cmt1_dst    = h1.dst;
  assign cmt1_data   = h1.data;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slots_d[i] = slots_q[i];
      if (flush) begin
        slots_d[i] = '0;
      end else begin
        if (fire0 && head_idx == IW'(i)) slots_d[i].valid = 1'b0;
        if (fire1 && next_idx == IW'(i)) slots_d[i].valid = 1'b0;
        // capture only into entries that are allocated and pending
        if (res0_valid && res0_tag == IW'(i) && slots_q[i].valid && !slots_q[i].ready) begin
          slots_d[i].ready = 1'b1;
          slots_d[i].data  = res0_data;
          slots_d[i].mis   = res0_mispred && (slots_q[i].kind == K_BRANCH);
        end
        if (res1_valid && res1_tag == IW'(i) && slots_q[i].valid && !slots_q[i].ready) begin
          slots_d[i].ready = 1'b1;
          slots_d[i].data  = res1_data;
          slots_d[i].mis   = res1_mispred && (slots_q[i].kind == K_BRANCH);
        end
        if (alloc0_gnt && alloc0_tag == IW'(i)) begin
          slots_d[i] = '{valid: 1'b1, ready: 1'b0, kind: op_kind_e'(alloc0_kind),
                         dst: alloc0_dst, data: '0, mis: 1'b0};
        end
        if (alloc1_gnt && alloc1_tag == IW'(i)) begin
          slots_d[i] = '{valid: 1'b1, ready: 1'b0, kind: op_kind_e'(alloc1_kind),
                         dst: alloc1_dst, data: '0, mis: 1'b0};
        end
      end
    end
  end

  assign head_d = flush ? head_q + PW'(1) : head_q + PW'(fire0) + PW'(fire1);
  assign tail_d = flush ? head_q + PW'(1) : tail_q + PW'(alloc0_gnt) + PW'(alloc1_gnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      slots_q <= slots_d;
    end
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc0_gnt,
  input logic          alloc1_gnt,
  input logic          fire0,
  input logic          fire1,
  input logic          flush,
  input logic [PW-1:0] occ,
  input logic          cmt0_reg_we,
  input logic          cmt0_mem_we,
  input logic          cmt1_reg_we,
  input logic          cmt1_mem_we
);
  a_r1_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));

  a_r2_full_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PW'(DEPTH)) |-> !alloc0_gnt);

  a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    alloc1_gnt |-> alloc0_gnt);

  a_r5_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
    fire1 |-> (fire0 && !flush));

  a_r6_flush_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(cmt0_reg_we || cmt0_mem_we || cmt1_reg_we || cmt1_mem_we));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  a_r7_no_alloc_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!alloc0_gnt && !alloc1_gnt));
endmodule

bind commit_buffer rob_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc0_gnt  (alloc0_gnt),
  .alloc1_gnt  (alloc1_gnt),
  .fire0       (fire0),
  .fire1       (fire1),
  .flush       (flush),
  .occ         (occ),
  .cmt0_reg_we (cmt0_reg_we),
  .cmt0_mem_we (cmt0_mem_we),
  .cmt1_reg_we (cmt1_reg_we),
  .cmt1_mem_we (cmt1_mem_we)
);

// File: tb/commit_buffer_tb.sv
module commit_buffer_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic alloc0_req, alloc1_req;
  logic [1:0] alloc0_kind, alloc1_kind;
  logic [4:0] alloc0_dst, alloc1_dst;
  logic alloc0_gnt, alloc1_gnt;
  logic [3:0] alloc0_tag, alloc1_tag;
  logic res0_valid, res1_valid, res0_mispred, res1_mispred;
  logic [3:0] res0_tag, res1_tag;
  logic [31:0] res0_data, res1_data;
  logic cmt0_reg_we, cmt0_mem_we, cmt1_reg_we, cmt1_mem_we, flush;
  logic [4:0] cmt0_dst, cmt1_dst;
  logic [31:0] cmt0_data, cmt1_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0] exp_tail;

  always #5 clk = ~clk;

  commit_buffer u_dut (.*);

  typedef struct packed {
    logic [1:0]  k0; logic [4:0] d0; logic [31:0] v0;
    logic [1:0]  k1; logic [4:0] d1; logic [31:0] v1;
    logic        swap;
  } row_t;

  // kinds: 0 register op, 1 store, 2 branch
  localparam row_t ROWS [8] = '{
    '{2'd0, 5'd1,  32'h1111_0001, 2'd0, 5'd2,  32'h2222_0002, 1'b0},
    '{2'd0, 5'd3,  32'h3333_0003, 2'd1, 5'd4,  32'h4444_0004, 1'b1},
    '{2'd1, 5'd5,  32'h5555_0005, 2'd0, 5'd6,  32'h6666_0006, 1'b0},
    '{2'd2, 5'd0,  32'h0000_0000, 2'd0, 5'd7,  32'h7777_0007, 1'b1},
    '{2'd0, 5'd31, 32'hFFFF_001F, 2'd2, 5'd0,  32'h0000_0000, 1'b0},
    '{2'd1, 5'd8,  32'h8888_0008, 2'd1, 5'd9,  32'h9999_0009, 1'b1},
    '{2'd0, 5'd10, 32'hAAAA_000A, 2'd0, 5'd11, 32'hBBBB_000B, 1'b1},
    '{2'd1, 5'd12, 32'hCCCC_000C, 2'd0, 5'd13, 32'hDDDD_000D, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    alloc0_req = 0; alloc1_req = 0; alloc0_kind = 0; alloc1_kind = 0;
    alloc0_dst = 0; alloc1_dst = 0;
    res0_valid = 0; res1_valid = 0; res0_mispred = 0; res1_mispred = 0;
    res0_tag = 0; res1_tag = 0; res0_data = 0; res1_data = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R8: reset state
    check("R8", "flush", flush, 0);
    check("R8", "cmt0 writes", {cmt0_reg_we, cmt0_mem_we}, 0);
    check("R8", "gnt without req", alloc0_gnt, 0);
    alloc0_req = 1; #1;
    check("R8", "first tag", alloc0_tag, 0);
    alloc0_req = 0; #1;
    exp_tail = 0;

    // table: pairs completed together or youngest first, then retired together
    for (int r = 0; r < 8; r++) begin
      logic [3:0] t0, t1;
      alloc0_req = 1; alloc0_kind = ROWS[r].k0; alloc0_dst = ROWS[r].d0;
      alloc1_req = 1; alloc1_kind = ROWS[r].k1; alloc1_dst = ROWS[r].d1;
      #1;
      check("R2", "pair grant", {alloc0_gnt, alloc1_gnt}, 2'b11);
      check("R1", "tag0", alloc0_tag, exp_tail);
      check("R1", "tag1", alloc1_tag, 4'(exp_tail + 1));
      t0 = exp_tail; t1 = 4'(exp_tail + 1); exp_tail = 4'(exp_tail + 2);
      tick();
      idle();
      if (!ROWS[r].swap) begin
        res0_valid = 1; res0_tag = t0; res0_data = ROWS[r].v0;
        res1_valid = 1; res1_tag = t1; res1_data = ROWS[r].v1;
        tick();
        idle();
      end else begin
        res0_valid = 1; res0_tag = t1; res0_data = ROWS[r].v1;
        tick();
        idle();
        check("R4", "head not ready holds", {cmt0_reg_we, cmt0_mem_we, cmt1_reg_we, cmt1_mem_we}, 0);
        res1_valid = 1; res1_tag = t0; res1_data = ROWS[r].v0;
        tick();
        idle();
      end
      check("R4", "slot0 flags", {cmt0_reg_we, cmt0_mem_we}, {ROWS[r].k0 == 2'd0, ROWS[r].k0 == 2'd1});
      if (ROWS[r].k0 != 2'd2) begin
        check("R4", "slot0 dst", cmt0_dst, ROWS[r].d0);
        check("R4", "slot0 data", cmt0_data, ROWS[r].v0);
      end
      check("R5", "slot1 flags", {cmt1_reg_we, cmt1_mem_we}, {ROWS[r].k1 == 2'd0, ROWS[r].k1 == 2'd1});
      if (ROWS[r].k1 != 2'd2) begin
        check("R5", "slot1 dst", cmt1_dst, ROWS[r].d1);
        check("R5", "slot1 data", cmt1_data, ROWS[r].v1);
      end
      check("R6", "no flush", flush, 0);
      tick();
    end

    // mispredicted branch behind a ready register op
    check("R1", "wrapped tag", exp_tail, 0);
    alloc0_req = 1; alloc0_kind = 0; alloc0_dst = 3;
    alloc1_req = 1; alloc1_kind = 2; alloc1_dst = 0;
    tick();
    idle();
    res0_valid = 1; res0_tag = 0; res0_data = 32'h55;
    res1_valid = 1; res1_tag = 1; res1_mispred = 1;
    tick();
    idle();
    check("R4", "reg commit before branch", {cmt0_reg_we, cmt0_dst, cmt0_data}, {1'b1, 5'd3, 32'h55});
    check("R5", "slot1 held at mispredict", {cmt1_reg_we, cmt1_mem_we, flush}, 0);
    tick();
    check("R6", "flush raised", flush, 1);
    check("R6", "no write on flush", {cmt0_reg_we, cmt0_mem_we, cmt1_reg_we, cmt1_mem_we}, 0);
    alloc0_req = 1; alloc1_req = 1; #1;
    check("R7", "no grant during flush", {alloc0_gnt, alloc1_gnt}, 0);
    idle();
    tick();
    exp_tail = 2;

    // fill to capacity
    for (int p = 0; p < 7; p++) begin
      alloc0_req = 1; alloc0_kind = (p == 0) ? 2'd2 : 2'd0; alloc0_dst = 5'(p);
      alloc1_req = 1; alloc1_kind = 0; alloc1_dst = 5'(p + 16);
      tick();
    end
    alloc1_req = 0; alloc0_kind = 0;
    tick();
    alloc0_req = 1; alloc1_req = 1; #1;
    check("R2", "one free slot", {alloc0_gnt, alloc1_gnt}, 2'b10);
    check("R1", "tag after wrap", alloc0_tag, 1);
    tick();
    alloc1_req = 0; #1;
    check("R2", "full refuses", alloc0_gnt, 0);
    idle();
    res0_valid = 1; res0_tag = 2; res0_mispred = 1;
    tick();
    idle();
    check("R6", "flush from full", flush, 1);
    tick();

    // stale write to a freed slot, then reuse of that slot
    res0_valid = 1; res0_tag = 3; res0_data = 32'hDEAD;
    tick();
    idle();
    alloc0_req = 1; alloc0_kind = 0; alloc0_dst = 9; #1;
    check("R6", "tag after flush", alloc0_tag, 3);
    check("R6", "empty after flush", alloc0_gnt, 1);
    tick();
    idle();
    check("R3", "stale write ignored", {cmt0_reg_we, cmt0_mem_we}, 0);
    res0_valid = 1; res0_tag = 3; res0_data = 32'h77;
    tick();
    idle();
    check("R3", "captured result commits", {cmt0_reg_we, cmt0_dst, cmt0_data}, {1'b1, 5'd9, 32'h77});
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule